// File: doc/BRIEF.md
# Per-Strand Pause Counter

This block lets a hardware thread (strand) give up its share of a core for a programmed number of clock cycles, so that other runnable strands can use the issue slots. Software writes a requested cycle count into the strand's pause register. The block drops the low three bits of that count, which turns it into 8-cycle units, and loads the result into a down-counter. While the counter runs, the strand's blocked output stays high. The block ends the pause when the counter runs out or when a disrupting trap arrives for that strand. When a pause ends, the blocked output falls and a one-cycle wake pulse fires in the same cycle.

The block holds one independent pause unit per strand. All strands share one write port. A select field picks which strand's pause register the write lands in. Each strand has its own trap input, blocked output and wake output. The issue logic that acts on the blocked signals lies outside this block.

Top module: `pause_array`

## Requirements
- R1: A write of value v (v >= 8, no trap on that strand in that cycle) raises the strand's blocked output in the cycle after the write. The output then stays high for exactly 8*(v>>3) consecutive cycles.
- R2: The counter steps down once every 8 cycles. Bits [2:0] of the written value do not affect the pause length, so a write of 23 blocks for the same 16 cycles as a write of 16.
- R3: A write of a value below 8 blocks the strand for exactly one cycle.
- R4: In the cycle where the blocked output first reads low after a pause, the wake output is high for that one cycle only. Wake is never high while blocked is high, and never high without a pause just ending.
- R5: A trap on a blocked strand, with no write to that strand in the same cycle, makes blocked read low and wake read high in the next cycle.
- R6: A trap in the same cycle as a write to that strand wins. Blocked reads low in the next cycle. Wake pulses only if the strand was already blocked.
- R7: A write to a strand that is already blocked restarts its pause. The strand then stays blocked for 8*(v>>3) cycles counted from the new write (one cycle if v < 8), and no wake pulse fires at the restart.
- R8: A write lands only in the strand whose index equals wr_sel, and a trap affects only its own strand. The other strands' blocked and wake outputs do not change.
- R9: After reset, all blocked and wake outputs are low.
- R10: A trap on a strand that is not blocked has no effect: blocked and wake both stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Pause register write strobe |
| wr_sel | input | SEL_W | Strand index for the write |
| wr_data | input | DATA_W | Requested pause length in cycles |
| trap_i | input | NUM_STRANDS | Disrupting trap, one bit per strand |
| blocked_o | output | NUM_STRANDS | Strand is paused, one bit per strand |
| wake_o | output | NUM_STRANDS | One-cycle pulse when a pause ends, one bit per strand |

## Verification
The bench measures exact pause lengths at the 8-cycle boundary and just below it. A prescaler that is off by one, or that is not cleared on a write, would stretch or shorten these pauses by up to a unit. Small values below 8 and a zero value are checked to give one blocked cycle; a design that loaded zero units as "no pause", or that never ended a zero-unit pause, would fail here. A trap in the same cycle as a write is checked both from idle and from a running pause. This catches a write that wrongly takes priority, and catches a missing or spurious wake pulse. A reload in the middle of a pause, traps on idle strands, and writes to one strand while another pauses are also checked. These expose a counter that keeps its old value and select logic that leaks into other strands.

// File: rtl/pause_pkg.sv
package pause_pkg;

  // Run state of one strand's pause unit
  typedef enum logic [0:0] {
    PS_IDLE    = 1'b0,
    PS_BLOCKED = 1'b1
  } pause_state_e;

  // Width of a strand select field for a given strand count
  function automatic int sel_width(input int strands);
    return (strands > 1) ? $clog2(strands) : 1;
  endfunction

endpackage

// File: rtl/pause_prescaler.sv
module pause_prescaler #(
  parameter int GRAN_LOG2 = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);

  localparam logic [GRAN_LOG2-1:0] WRAP_VAL = '1;

  logic [GRAN_LOG2-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign tick = run && (phase_q == WRAP_VAL);

  // R2: while running and not cleared, the phase advances by one each cycle
  a_r2_phase_steps: assert property (@(posedge clk) disable iff (rst)
    (run && !clear) |=> (phase_q == $past(phase_q) + 1'b1));

  // R2: a clear always restarts the phase from zero
  a_r2_phase_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> (phase_q == '0));

endmodule

// File: rtl/pause_unit_counter.sv
module pause_unit_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic             clr,
  output logic             last,
  output logic             zero
);

  logic [CNT_W-1:0] units_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      units_q <= '0;
    end else if (load) begin
      units_q <= load_val;
    end else if (dec && (units_q != '0)) begin
      units_q <= units_q - 1'b1;
    end
  end

  assign last = (units_q == CNT_W'(1));
  assign zero = (units_q == '0);

  // R2: one step down per enabled decrement
  a_r2_dec_step: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && !clr && !zero) |=> (units_q == $past(units_q) - 1'b1));

  // R7: a load takes the new value unless cleared in the same cycle
  a_r7_load_val: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> (units_q == $past(load_val)));

endmodule

// File: rtl/pause_strand.sv
module pause_strand
  import pause_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int GRAN_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trap,
  output logic              blocked_o,
  output logic              wake_o
);

  localparam int CNT_W = DATA_W - GRAN_LOG2;

  pause_state_e     state_q;
  logic             wake_q;
  logic             is_blocked;
  logic             load;
  logic             finish;
  logic             tick;
  logic             last;
  logic             zero;
  logic [CNT_W-1:0] units;

  assign is_blocked = (state_q == PS_BLOCKED);
  assign units      = CNT_W'(wr_data >> GRAN_LOG2);

  // A trap beats a write; a write beats a natural end.
  assign load   = wr_fire && !trap;
  assign finish = is_blocked && (trap || (!wr_fire && (zero || (tick && last))));

  pause_prescaler #(
    .GRAN_LOG2 (GRAN_LOG2)
  ) u_presc (
    .clk   (clk),
    .rst   (rst),
    .clear (load || finish),
    .run   (is_blocked),
    .tick  (tick)
  );

  pause_unit_counter #(
    .CNT_W (CNT_W)
  ) u_units (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (units),
    .dec      (tick && !load && !finish),
    .clr      (finish),
    .last     (last),
    .zero     (zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_IDLE;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= finish;
      if (load) begin
        state_q <= PS_BLOCKED;
      end else if (finish) begin
        state_q <= PS_IDLE;
      end
    end
  end

  assign blocked_o = is_blocked;
  assign wake_o    = wake_q;

  // R1: an accepted write blocks the strand in the next cycle
  a_r1_write_blocks: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !trap) |=> blocked_o);

  // R6: a trap always leaves the strand unblocked next cycle
  a_r6_trap_wins: assert property (@(posedge clk) disable iff (rst)
    trap |=> !blocked_o);

  // R5: a trap on a blocked strand produces a wake pulse
  a_r5_trap_wakes: assert property (@(posedge clk) disable iff (rst)
    (trap && blocked_o) |=> wake_o);

  // R3: a zero-unit pause lasts one cycle when not reloaded
  a_r3_short_ends: assert property (@(posedge clk) disable iff (rst)
    (blocked_o && zero && !wr_fire) |=> !blocked_o);

  // R4: wake only right after a blocked cycle, never with blocked high
  a_r4_wake_edge: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (!blocked_o && $past(blocked_o)));

  // R10: an idle strand seeing only a trap stays quiet
  a_r10_idle_trap: assert property (@(posedge clk) disable iff (rst)
    (!blocked_o && trap) |=> (!blocked_o && !wake_o));

endmodule

// File: rtl/pause_array.sv
module pause_array
  import pause_pkg::*;
#(
  parameter int NUM_STRANDS = 4,
  parameter int DATA_W      = 16,
  parameter int GRAN_LOG2   = 3,
  parameter int SEL_W       = sel_width(NUM_STRANDS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_valid,
  input  logic [SEL_W-1:0]       wr_sel,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [NUM_STRANDS-1:0] trap_i,
  output logic [NUM_STRANDS-1:0] blocked_o,
  output logic [NUM_STRANDS-1:0] wake_o
);

  logic [NUM_STRANDS-1:0] fire;

  for (genvar g = 0; g < NUM_STRANDS; g++) begin : g_strand
    assign fire[g] = wr_valid && (wr_sel == SEL_W'(g));

    pause_strand #(
      .DATA_W    (DATA_W),
      .GRAN_LOG2 (GRAN_LOG2)
    ) u_strand (
      .clk       (clk),
      .rst       (rst),
      .wr_fire   (fire[g]),
      .wr_data   (wr_data),
      .trap      (trap_i[g]),
      .blocked_o (blocked_o[g]),
      .wake_o    (wake_o[g])
    );
  end

  // R8: a write reaches at most one strand
  a_r8_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fire));

  // R9: outputs are quiet in the cycle after reset
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (blocked_o == '0 && wake_o == '0));

endmodule

// File: tb/pause_array_tb.sv
module pause_array_tb;

  localparam int N  = 4;
  localparam int DW = 16;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [SW-1:0] wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic [N-1:0]  trap_i = '0;
  logic [N-1:0]  blocked_o;
  logic [N-1:0]  wake_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pause_array #(.NUM_STRANDS(N), .DATA_W(DW), .GRAN_LOG2(3)) u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_sel(wr_sel),
    .wr_data(wr_data), .trap_i(trap_i), .blocked_o(blocked_o), .wake_o(wake_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one write (optionally with trap on the same strand); returns at the
  // negedge after the sampling edge.
  task automatic write_pause(input int s, input int v, input bit with_trap);
    wr_valid = 1'b1;
    wr_sel   = SW'(s);
    wr_data  = DW'(v);
    trap_i   = with_trap ? (N'(1) << s) : '0;
    @(negedge clk);
    wr_valid = 1'b0;
    trap_i   = '0;
  endtask

  task automatic pulse_trap(input int s);
    trap_i = N'(1) << s;
    @(negedge clk);
    trap_i = '0;
  endtask

  // Count blocked cycles from now; report length and wake at the falling cycle.
  task automatic measure(input int s, output int len, output bit woke);
    len = 0;
    while (blocked_o[s] && len < 100000) begin
      if (wake_o[s]) check(1'b0, "R4 wake while blocked", 1, 0);
      len++;
      @(negedge clk);
    end
    woke = wake_o[s];
    @(negedge clk);
    check(wake_o[s] == 1'b0, "R4 wake one cycle", int'(wake_o[s]), 0);
  endtask

  task automatic t_length(input int v, input int exp_len, input string req);
    int len; bit woke;
    write_pause(0, v, 1'b0);
    measure(0, len, woke);
    check(len == exp_len, req, len, exp_len);
    check(woke, "R4 wake at end", int'(woke), 1);
  endtask

  task automatic t_trap_mid();
    write_pause(1, 200, 1'b0);
    repeat (9) @(negedge clk);
    check(blocked_o[1], "R5 still blocked before trap", int'(blocked_o[1]), 1);
    pulse_trap(1);
    check(!blocked_o[1], "R5 trap ends pause", int'(blocked_o[1]), 0);
    check(wake_o[1], "R5 trap wake", int'(wake_o[1]), 1);
    @(negedge clk);
    check(!wake_o[1], "R5 wake single", int'(wake_o[1]), 0);
  endtask

  task automatic t_trap_with_write();
    write_pause(2, 64, 1'b1);
    check(!blocked_o[2], "R6 trap beats write idle", int'(blocked_o[2]), 0);
    check(!wake_o[2], "R6 no wake from idle", int'(wake_o[2]), 0);
    write_pause(2, 64, 1'b0);
    repeat (5) @(negedge clk);
    write_pause(2, 64, 1'b1);
    check(!blocked_o[2], "R6 trap beats write blocked", int'(blocked_o[2]), 0);
    check(wake_o[2], "R6 wake when was blocked", int'(wake_o[2]), 1);
    @(negedge clk);
  endtask

  task automatic t_reload();
    int len; bit woke;
    write_pause(3, 64, 1'b0);
    repeat (20) @(negedge clk);
    write_pause(3, 24, 1'b0);
    measure(3, len, woke);
    check(len == 24, "R7 reload length", len, 24);
    write_pause(3, 64, 1'b0);
    repeat (3) @(negedge clk);
    write_pause(3, 2, 1'b0);
    measure(3, len, woke);
    check(len == 1, "R7 reload short", len, 1);
  endtask

  task automatic t_independent();
    int len; bit woke;
    write_pause(0, 64, 1'b0);
    write_pause(2, 16, 1'b0);
    check(blocked_o == 4'b0101, "R8 only targeted strands", int'(blocked_o), 5);
    pulse_trap(1);
    check(!blocked_o[1] && !wake_o[1], "R10 idle trap ignored", int'(blocked_o[1]), 0);
    check(blocked_o[0] && blocked_o[2], "R8 trap stays local", int'(blocked_o), 5);
    measure(2, len, woke);
    check(len == 15, "R8 strand2 length", len, 15);
    check(blocked_o[0] && !wake_o[0], "R8 strand0 unaffected", int'(blocked_o[0]), 1);
    pulse_trap(0);
    check(blocked_o == '0, "R8 all idle", int'(blocked_o), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(blocked_o == '0, "R9 reset blocked", int'(blocked_o), 0);
    check(wake_o == '0, "R9 reset wake", int'(wake_o), 0);
    rst = 1'b0;
    @(negedge clk);
    t_length(64, 64, "R1 length 64");
    t_length(8, 8, "R1 length 8");
    t_length(23, 16, "R2 low bits ignored");
    t_length(15, 8, "R2 low bits 15");
    t_length(5, 1, "R3 short 5");
    t_length(0, 1, "R3 short 0");
    t_trap_mid();
    t_trap_with_write();
    t_reload();
    t_independent();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule